// File: doc/BRIEF.md
# Shared Interrupt Input Conditioner

This block takes a bank of external interrupt lines and turns each one into a pending bit. Every line has its own configuration: a polarity bit, a trigger bit (level or edge) and a dual-edge bit. Raw lines first pass through a two-stage synchronizer. In level mode the pending bit follows the qualified, synchronized line. In edge mode the selected edge or edges set a latch, and the latch holds until software clears it.

Every line also has a mask bit. The block sets and clears mask bits through two separate write-one registers, and a zero in either register leaves the bit alone. A software edge register lets one write set or clear the edge latch of any one interrupt. The clear form is how software acknowledges an edge interrupt.

The block drives the pending vector and the mask vector to the routing logic that follows it. A plain synchronous write / combinational read port reaches all the state. Bits are packed 32 per word, with word `k` at byte offset `4*k` inside each register region.

Top module: `irq_cond`

## Requirements
- R1: After reset, every polarity, trigger, dual-edge and mask bit is 0, so each line is positive, level-sensitive and masked. With all inputs low, `pend_o` and `mask_o` are zero.
- R2: In level mode with polarity 0, a pending bit is 1 while its line is high. A change on the line reaches `pend_o` after two rising clock edges and not after one.
- R3: In level mode with polarity 1, a pending bit is 1 while its line is low. A polarity write takes effect right after the write edge.
- R4: In edge mode (trigger bit 1) with polarity 0 and dual-edge 0, a rising edge on the line sets pending three clock edges after the input change. Pending then stays set after the line falls.
- R5: In edge mode with polarity 1 and dual-edge 0, only a falling edge sets pending. A rising edge leaves it clear.
- R6: In edge mode with dual-edge 1, both rising and falling edges set pending, whatever the polarity bit holds.
- R7: Writing region 0x400, word `k`, sets every mask bit whose write-data bit is 1. All other mask bits are unchanged.
- R8: Writing region 0x500, word `k`, clears every mask bit whose write-data bit is 1. All other mask bits are unchanged.
- R9: A write to the software edge register (0x700) uses data bit 31 as the action (1 = set, 0 = clear) and the low `log2(NUM_IRQ)` bits as the interrupt number. On an edge-mode interrupt it sets or clears the pending latch at that write edge.
- R10: In level mode the edge latch is held clear. A software set then has no effect on pending, and changing an edge interrupt with a latched pending back to level mode drops the latched state.
- R11: Address map, with bits [10:8] selecting the region and bits [7:2] selecting the word: 0x000 polarity, 0x100 trigger, 0x200 dual-edge (all read/write), 0x300 mask (read), 0x600 pending (read). Regions 0x400, 0x500 and 0x700 read as zero. Interrupt `n` sits in word `n/32`, bit `n%32`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Raw asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 11 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pend_o | output | NUM_IRQ | Pending vector |
| mask_o | output | NUM_IRQ | Mask vector (1 = enabled) |

## Verification
The bench checks the exact latency of the synchronizer. A design with one stage too few would raise a level pending one cycle early, and the check after a single edge would catch it. Edge tests drop the line after it has latched and look for the bit to stay set. A design that treated edge mode as level would clear it. Falling-edge, dual-edge and software set/clear cases show up designs that ignore polarity or the action bit. Mask writes with zero bits in other words show up a design that writes a whole word where it should touch single bits. Writes to the second word show up broken address decoding.

// File: rtl/irq_cond.sv
module irq_cond #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [10:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] mask_o
);
  localparam int NWORDS = NUM_IRQ / 32;
  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam logic [2:0] RG_POL = 3'd0, RG_TRIG = 3'd1, RG_DUAL = 3'd2, RG_MASK = 3'd3,
                         RG_SETM = 3'd4, RG_CLRM = 3'd5, RG_PEND = 3'd6, RG_SWE = 3'd7;

  logic [NUM_IRQ-1:0] s1, s2, s3, pol_q, trig_q, dual_q, mask_q, lat_q;
  logic [NUM_IRQ-1:0] rise, fall, act, edge_hit, sw_vec, sw_set, sw_clr;
  logic [2:0]       region;
  logic [5:0]       widx;
  logic             wr_ok, w_valid, sw_wr, sw_valid;
  logic [IDX_W-1:0] sw_idx;

  assign region   = reg_addr[10:8];
  assign widx     = reg_addr[7:2];
  assign w_valid  = int'(widx) < NWORDS;
  assign wr_ok    = reg_wr && (reg_addr[1:0] == 2'b00);
  assign sw_idx   = reg_wdata[IDX_W-1:0];
  assign sw_valid = int'(sw_idx) < NUM_IRQ;
  assign sw_wr    = wr_ok && region == RG_SWE && sw_valid;
  assign sw_vec   = {{(NUM_IRQ-1){1'b0}}, 1'b1} << sw_idx;
  assign sw_set   = (sw_wr &&  reg_wdata[31]) ? sw_vec : '0;
  assign sw_clr   = (sw_wr && !reg_wdata[31]) ? sw_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= irq_in; s2 <= s1; s3 <= s2;
    end
  end

  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign act      = s2 ^ pol_q;
  assign edge_hit = trig_q & ((dual_q & (rise | fall)) | (~dual_q & ~pol_q & rise) | (~dual_q & pol_q & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0; trig_q <= '0; dual_q <= '0; mask_q <= '0;
    end else if (wr_ok) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (int'(widx) == w) begin
          case (region)
            RG_POL:  pol_q[w*32 +: 32]  <= reg_wdata;
            RG_TRIG: trig_q[w*32 +: 32] <= reg_wdata;
            RG_DUAL: dual_q[w*32 +: 32] <= reg_wdata;
            RG_SETM: mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] | reg_wdata;
            RG_CLRM: mask_q[w*32 +: 32] <= mask_q[w*32 +: 32] & ~reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= trig_q & (edge_hit | (lat_q & ~sw_clr) | sw_set);
  end

  assign pend_o = (trig_q & lat_q) | (~trig_q & act);
  assign mask_o = mask_q;

  always_comb begin
    reg_rdata = '0;
    if (w_valid) begin
      case (region)
        RG_POL:  reg_rdata = pol_q[int'(widx)*32 +: 32];
        RG_TRIG: reg_rdata = trig_q[int'(widx)*32 +: 32];
        RG_DUAL: reg_rdata = dual_q[int'(widx)*32 +: 32];
        RG_MASK: reg_rdata = mask_q[int'(widx)*32 +: 32];
        RG_PEND: reg_rdata = pend_o[int'(widx)*32 +: 32];
        default: reg_rdata = '0;
      endcase
    end
  end

  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && region == RG_SETM && widx == 6'd0) |=>
      ((mask_o[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && region == RG_CLRM && widx == 6'd0) |=>
      ((mask_o[31:0] & $past(reg_wdata)) == 32'd0));

  a_r9_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && reg_wdata[31] && trig_q[sw_idx]) |=> pend_o[$past(sw_idx)]);

  a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !reg_wdata[31] && trig_q[sw_idx] && !edge_hit[sw_idx]) |=> !pend_o[$past(sw_idx)]);

  a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q[0] && pend_o[0] && !reg_wr) |=> pend_o[0]);
endmodule

// File: tb/irq_cond_tb.sv
module irq_cond_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic          clk = 0, rst_n = 0, reg_wr = 0;
  logic [N-1:0]  irq_in = '0;
  logic [10:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic [N-1:0]  pend_o, mask_o;
  int total = 0, bad = 0;

  irq_cond #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_o(pend_o), .mask_o(mask_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [10:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pend", pend_o, 64'd0);
    chk("R1 mask", mask_o, 64'd0);
    rd("R1 pol", 11'h000, 32'd0);
    rd("R1 trig", 11'h104, 32'd0);
    rd("R1 dual", 11'h200, 32'd0);
  endtask

  task automatic t_level;
    @(negedge clk); irq_in[3] = 1;
    wait_n(1); chk("R2 one edge", 64'(pend_o[3]), 64'd0);
    wait_n(1); chk("R2 two edges", 64'(pend_o[3]), 64'd1);
    irq_in[3] = 0;
    wait_n(2); chk("R2 drop", 64'(pend_o[3]), 64'd0);
  endtask

  task automatic t_level_neg;
    wr(11'h000, 32'h0000_0020);
    chk("R3 low active", 64'(pend_o[5]), 64'd1);
    irq_in[5] = 1;
    wait_n(2); chk("R3 high idle", 64'(pend_o[5]), 64'd0);
    rd("R11 pol readback", 11'h000, 32'h0000_0020);
  endtask

  task automatic t_edge_rise;
    wr(11'h104, 32'h0000_0100);
    irq_in[40] = 1;
    wait_n(3); chk("R4 rise latch", 64'(pend_o[40]), 64'd1);
    irq_in[40] = 0;
    wait_n(3); chk("R4 hold", 64'(pend_o[40]), 64'd1);
    rd("R11 pend word1", 11'h604, 32'h0000_0100);
    wr(11'h700, 32'd40);
    chk("R9 sw clear", 64'(pend_o[40]), 64'd0);
    wr(11'h700, 32'h8000_0000 | 32'd40);
    chk("R9 sw set", 64'(pend_o[40]), 64'd1);
  endtask

  task automatic t_edge_fall;
    wr(11'h004, 32'h0000_0200);
    wr(11'h104, 32'h0000_0300);
    irq_in[41] = 1;
    wait_n(3); chk("R5 rise ignored", 64'(pend_o[41]), 64'd0);
    irq_in[41] = 0;
    wait_n(3); chk("R5 fall latch", 64'(pend_o[41]), 64'd1);
    wr(11'h700, 32'd41);
  endtask

  task automatic t_dual;
    wr(11'h004, 32'h0000_0600);
    wr(11'h104, 32'h0000_0700);
    wr(11'h204, 32'h0000_0400);
    irq_in[42] = 1;
    wait_n(3); chk("R6 rise", 64'(pend_o[42]), 64'd1);
    wr(11'h700, 32'd42);
    chk("R6 cleared", 64'(pend_o[42]), 64'd0);
    irq_in[42] = 0;
    wait_n(3); chk("R6 fall", 64'(pend_o[42]), 64'd1);
  endtask

  task automatic t_mask;
    wr(11'h400, 32'h0000_0011);
    chk("R7 set word0", 64'(mask_o[31:0]), 64'h11);
    wr(11'h404, 32'h0000_0001);
    chk("R7 set word1", mask_o, 64'h0000_0001_0000_0011);
    wr(11'h500, 32'h0000_0001);
    chk("R8 clr word0", mask_o, 64'h0000_0001_0000_0010);
    rd("R11 mask read", 11'h300, 32'h0000_0010);
    rd("R11 setmask reads 0", 11'h400, 32'd0);
  endtask

  task automatic t_level_sw;
    wr(11'h700, 32'h8000_0000 | 32'd3);
    chk("R10 sw set on level", 64'(pend_o[3]), 64'd0);
    chk("R10 pre latched", 64'(pend_o[40]), 64'd1);
    wr(11'h104, 32'h0000_0000);
    chk("R10 level drops latch", 64'(pend_o[40]), 64'd0);
    wr(11'h104, 32'h0000_0100);
    chk("R10 latch not restored", 64'(pend_o[40]), 64'd0);
  endtask

  initial begin
    wait_n(3); rst_n = 1; wait_n(1);
    t_reset();
    t_level();
    t_level_neg();
    t_edge_rise();
    t_edge_fall();
    t_dual();
    t_mask();
    t_level_sw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule